// File: doc/BRIEF.md
# AUX Request Header Builder and Reply Decoder

This block sits between a display-link software-facing command port and a lower engine that moves bytes over the auxiliary sideband channel. It accepts one command at a time, made of a 16-bit target address, a 4-bit request type, a payload length, the requester's receive-buffer size and a flat payload buffer. It serializes a four-byte header, followed by the write payload when there is one, as a byte stream with a valid/ready handshake and a last-byte marker.

When the lower engine returns a status byte, a received length and received data, the block turns these into a result code, a 4-bit reply code and a clamped byte count. It presents them as a single-cycle completion pulse. Commands that are too long or that carry an unsupported request type complete at once, without any byte leaving the block.

Top module: `aux_req_codec`

## Requirements
- R1: The first three streamed bytes are, in order: address bits 7:0, address bits 15:8, and the full 4-bit request type placed in bits 7:4 with bits 3:0 zero.
- R2: Bits 3:0 of the fourth header byte hold the payload length minus one, or 0 when the length is 0.
- R3: Bits 7:4 of the fourth header byte are 3 when the length is 0. Otherwise they are 4 for a read and (4 + length) modulo 16 for a write.
- R4: A command whose length exceeds MAX_PAY (16) completes on the next cycle with result 4 (too big). No byte is streamed. This check takes priority over the request-type check.
- R5: For a write, 4 + length bytes are streamed, with payload byte i taken from cmd_wdata[8i+7:8i] and sent in increasing i after the header. For a read, exactly 4 bytes are streamed. tx_last marks the final byte. While tx_ready is low, tx_valid, tx_data and tx_last hold.
- R6: Bit 2 of the request type (continue-transaction) is ignored when classifying. After clearing it, 0 and 8 are writes and 1 and 9 are reads. Any other value completes on the next cycle with result 5 (invalid) and no byte streamed.
- R7: A returned status of exactly 1 gives result 1 (timeout), 2 gives result 2 (flags not zero), and 3 gives result 3 (error). Each of these reports reply 0, count 0 and all-zero data.
- R8: Any other status gives result 0 (ok) with reply equal to status bits 7:4. A read reports min(returned length, buffer size, MAX_PAY) as its count, passes that many low data bytes and zeroes the rest. A write reports its payload length and all-zero data.
- R9: cmd_ready is low from the cycle after a streamed command is accepted until its reply is decoded. done_valid is a one-cycle pulse, and cmd_ready is high again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_addr | input | 16 | Target address |
| cmd_req | input | 4 | Request type |
| cmd_len | input | LEN_W (6) | Payload length in bytes |
| cmd_rbuf | input | LEN_W (6) | Requester receive-buffer size |
| cmd_wdata | input | MAX_PAY*8 (128) | Write payload, byte i at bits 8i+7:8i |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Lower engine takes byte |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the request |
| rsp_valid | input | 1 | Reply from lower engine present |
| rsp_status | input | 8 | Returned status byte |
| rsp_len | input | LEN_W (6) | Number of bytes returned |
| rsp_data | input | MAX_PAY*8 (128) | Returned bytes |
| done_valid | output | 1 | Completion pulse |
| done_result | output | 3 | 0 ok, 1 timeout, 2 flags, 3 error, 4 too big, 5 invalid |
| done_reply | output | 4 | Reply code |
| done_count | output | LEN_W (6) | Reported byte count |
| done_data | output | MAX_PAY*8 (128) | Reply bytes, beyond count zeroed |

## Verification
The hardest cases to reach are the wrap of the total-length nibble (a 12-byte write gives 0, a 16-byte write gives 4) and a status byte whose low nibble looks like an error code but whose full value is not. Both are reached only by choosing exact length and status values, so the bench drives those values on purpose. The bench also combines random back-pressure on tx_ready with mid-stream stalls, so the hold behaviour is checked on header and payload bytes alike. Read clamping is reached by returning more bytes than the requester's buffer and checking that the tail bytes are zeroed.

// File: rtl/aux_codec_pkg.sv
`timescale 1ns/1ps
package aux_codec_pkg;
   localparam int HDR_BYTES = 4;
   localparam logic [3:0] BARE_CODE = 4'd3;
   localparam logic [3:0] KIND_MASK = 4'b1011;

   typedef enum logic [2:0] {
      RES_OK      = 3'd0,
      RES_TIMEOUT = 3'd1,
      RES_FLAGS   = 3'd2,
      RES_IO_ERR  = 3'd3,
      RES_TOO_BIG = 3'd4,
      RES_INVALID = 3'd5
   } aux_result_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2
   } aux_state_e;
endpackage

// File: rtl/aux_hdr_build.sv
`timescale 1ns/1ps
module aux_hdr_build
   import aux_codec_pkg::*;
#(
   parameter int MAX_PAY = 16,
   parameter int LEN_W   = 6,
   parameter int CNT_W   = 5
) (
   input  logic [15:0]      addr,
   input  logic [3:0]       req,
   input  logic [LEN_W-1:0] len,
   output logic [31:0]      hdr,
   output logic             is_write,
   output logic             req_ok,
   output logic             too_big,
   output logic [CNT_W-1:0] tx_count
);
   logic [3:0]       kind;
   logic             is_read;
   logic [LEN_W-1:0] len_m1;
   logic [LEN_W-1:0] total;
   logic [3:0]       lo_nib;
   logic [3:0]       hi_nib;

   assign kind     = req & KIND_MASK;
   assign is_read  = (kind == 4'h1) || (kind == 4'h9);
   assign is_write = (kind == 4'h0) || (kind == 4'h8);
   assign req_ok   = is_read || is_write;
   assign too_big  = len > LEN_W'(MAX_PAY);

   assign len_m1 = len - LEN_W'(1);
   assign total  = LEN_W'(HDR_BYTES) + len;
   assign lo_nib = (len == '0) ? 4'd0 : len_m1[3:0];

   always_comb begin
      if (len == '0)
         hi_nib = BARE_CODE;
      else if (is_write)
         hi_nib = total[3:0];
      else
         hi_nib = 4'(HDR_BYTES);
   end

   assign hdr      = {hi_nib, lo_nib, req, 4'h0, addr[15:8], addr[7:0]};
   assign tx_count = is_write ? (CNT_W'(HDR_BYTES) + CNT_W'(len)) : CNT_W'(HDR_BYTES);
endmodule

// File: rtl/aux_tx_seq.sv
`timescale 1ns/1ps
module aux_tx_seq
   import aux_codec_pkg::*;
#(
   parameter int MAX_PAY = 16,
   parameter int CNT_W   = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [31:0]          hdr,
   input  logic [MAX_PAY*8-1:0] payload,
   input  logic [CNT_W-1:0]     count,
   input  logic                 tx_ready,
   output logic                 tx_valid,
   output logic [7:0]           tx_data,
   output logic                 tx_last,
   output logic                 finished
);
   localparam int FRAME = HDR_BYTES + MAX_PAY;

   logic                 active;
   logic [CNT_W-1:0]     idx;
   logic [CNT_W-1:0]     cnt_q;
   logic [31:0]          hdr_q;
   logic [MAX_PAY*8-1:0] pay_q;
   logic [7:0]           frame_b [FRAME];

   for (genvar g = 0; g < FRAME; g++) begin : g_frame
      if (g < HDR_BYTES) begin : g_hdr
         assign frame_b[g] = hdr_q[8*g +: 8];
      end else begin : g_pay
         assign frame_b[g] = pay_q[8*(g-HDR_BYTES) +: 8];
      end
   end

   always_comb begin
      tx_data = 8'h00;
      for (int k = 0; k < FRAME; k++)
         if (idx == CNT_W'(k)) tx_data = frame_b[k];
   end

   assign tx_valid = active;
   assign tx_last  = active && (idx == cnt_q - CNT_W'(1));
   assign finished = tx_valid && tx_ready && tx_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         cnt_q  <= '0;
         hdr_q  <= '0;
         pay_q  <= '0;
      end else if (start) begin
         active <= 1'b1;
         idx    <= '0;
         cnt_q  <= count;
         hdr_q  <= hdr;
         pay_q  <= payload;
      end else if (tx_valid && tx_ready) begin
         if (tx_last) active <= 1'b0;
         else         idx    <= idx + CNT_W'(1);
      end
   end

   assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);
endmodule

// File: rtl/aux_rsp_decode.sv
`timescale 1ns/1ps
module aux_rsp_decode
   import aux_codec_pkg::*;
#(
   parameter int MAX_PAY = 16,
   parameter int LEN_W   = 6
) (
   input  logic [7:0]           status,
   input  logic [LEN_W-1:0]     rsp_len,
   input  logic [MAX_PAY*8-1:0] rsp_data,
   input  logic                 is_write,
   input  logic [LEN_W-1:0]     wr_len,
   input  logic [LEN_W-1:0]     rbuf,
   output aux_result_e          result,
   output logic [3:0]           reply,
   output logic [LEN_W-1:0]     count,
   output logic [MAX_PAY*8-1:0] data
);
   logic             ok;
   logic             pass;
   logic [LEN_W-1:0] lim_a;
   logic [LEN_W-1:0] lim_b;

   always_comb begin
      case (status)
         8'd1:    result = RES_TIMEOUT;
         8'd2:    result = RES_FLAGS;
         8'd3:    result = RES_IO_ERR;
         default: result = RES_OK;
      endcase
   end

   assign ok    = (result == RES_OK);
   assign pass  = ok && !is_write;
   assign reply = ok ? status[7:4] : 4'd0;
   assign lim_a = (rbuf < rsp_len) ? rbuf : rsp_len;
   assign lim_b = (lim_a > LEN_W'(MAX_PAY)) ? LEN_W'(MAX_PAY) : lim_a;

   always_comb begin
      if (!ok)          count = '0;
      else if (is_write) count = wr_len;
      else              count = lim_b;
   end

   for (genvar g = 0; g < MAX_PAY; g++) begin : g_mask
      assign data[8*g +: 8] = (pass && (LEN_W'(g) < count)) ? rsp_data[8*g +: 8] : 8'h00;
   end
endmodule

// File: rtl/aux_req_codec.sv
`timescale 1ns/1ps
module aux_req_codec
   import aux_codec_pkg::*;
#(
   parameter int MAX_PAY = 16,
   parameter int LEN_W   = (($clog2(MAX_PAY+1) + 1) < 5) ? 5 : ($clog2(MAX_PAY+1) + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic [15:0]          cmd_addr,
   input  logic [3:0]           cmd_req,
   input  logic [LEN_W-1:0]     cmd_len,
   input  logic [LEN_W-1:0]     cmd_rbuf,
   input  logic [MAX_PAY*8-1:0] cmd_wdata,
   output logic                 tx_valid,
   input  logic                 tx_ready,
   output logic [7:0]           tx_data,
   output logic                 tx_last,
   input  logic                 rsp_valid,
   input  logic [7:0]           rsp_status,
   input  logic [LEN_W-1:0]     rsp_len,
   input  logic [MAX_PAY*8-1:0] rsp_data,
   output logic                 done_valid,
   output logic [2:0]           done_result,
   output logic [3:0]           done_reply,
   output logic [LEN_W-1:0]     done_count,
   output logic [MAX_PAY*8-1:0] done_data
);
   localparam int CNT_W = $clog2(MAX_PAY + HDR_BYTES + 1);

   if (MAX_PAY < 1 || MAX_PAY > 16) begin : g_bad_pay
      $error("MAX_PAY must lie in 1..16");
   end
   if (LEN_W < $clog2(MAX_PAY+1) + 1) begin : g_bad_len
      $error("LEN_W too narrow to flag oversize lengths");
   end

   aux_state_e           state;
   logic                 accept;
   logic [31:0]          hdr;
   logic                 hb_write;
   logic                 hb_ok;
   logic                 hb_big;
   logic [CNT_W-1:0]     hb_count;
   logic                 seq_start;
   logic                 seq_done;
   logic                 wr_q;
   logic [LEN_W-1:0]     len_q;
   logic [LEN_W-1:0]     rbuf_q;
   aux_result_e          dec_res;
   logic [3:0]           dec_reply;
   logic [LEN_W-1:0]     dec_count;
   logic [MAX_PAY*8-1:0] dec_data;

   assign cmd_ready = (state == ST_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign seq_start = accept && !hb_big && hb_ok;

   aux_hdr_build #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W), .CNT_W(CNT_W)) hdr_i (
      .addr(cmd_addr), .req(cmd_req), .len(cmd_len), .hdr(hdr),
      .is_write(hb_write), .req_ok(hb_ok), .too_big(hb_big), .tx_count(hb_count)
   );

   aux_tx_seq #(.MAX_PAY(MAX_PAY), .CNT_W(CNT_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(seq_start), .hdr(hdr), .payload(cmd_wdata),
      .count(hb_count), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last), .finished(seq_done)
   );

   aux_rsp_decode #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) dec_i (
      .status(rsp_status), .rsp_len(rsp_len), .rsp_data(rsp_data), .is_write(wr_q),
      .wr_len(len_q), .rbuf(rbuf_q), .result(dec_res), .reply(dec_reply),
      .count(dec_count), .data(dec_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         wr_q        <= 1'b0;
         len_q       <= '0;
         rbuf_q      <= '0;
         done_valid  <= 1'b0;
         done_result <= RES_OK;
         done_reply  <= '0;
         done_count  <= '0;
         done_data   <= '0;
      end else begin
         done_valid <= 1'b0;
         case (state)
            ST_IDLE: if (accept) begin
               wr_q   <= hb_write;
               len_q  <= cmd_len;
               rbuf_q <= cmd_rbuf;
               if (hb_big || !hb_ok) begin
                  done_valid  <= 1'b1;
                  done_result <= hb_big ? RES_TOO_BIG : RES_INVALID;
                  done_reply  <= '0;
                  done_count  <= '0;
                  done_data   <= '0;
               end else begin
                  state <= ST_SEND;
               end
            end
            ST_SEND: if (seq_done) state <= ST_WAIT;
            ST_WAIT: if (rsp_valid) begin
               state       <= ST_IDLE;
               done_valid  <= 1'b1;
               done_result <= dec_res;
               done_reply  <= dec_reply;
               done_count  <= dec_count;
               done_data   <= dec_data;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_oversize_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (cmd_len > LEN_W'(MAX_PAY))) |=>
      (done_valid && done_result == RES_TOO_BIG && !tx_valid));

   assert_bad_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (cmd_len <= LEN_W'(MAX_PAY)) &&
       !((cmd_req & KIND_MASK) inside {4'h0, 4'h1, 4'h8, 4'h9})) |=>
      (done_valid && done_result == RES_INVALID && !tx_valid));

   assert_err_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && (done_result inside {RES_TIMEOUT, RES_FLAGS, RES_IO_ERR})) |->
      (done_reply == 4'd0 && done_count == '0 && done_data == '0));

   assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (done_count <= LEN_W'(MAX_PAY)));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!cmd_ready || done_valid));

   assert_ready_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> cmd_ready);
endmodule

// File: tb/aux_req_codec_tb.sv
`timescale 1ns/1ps
module aux_req_codec_tb_top;
   localparam int MAX_PAY = 16;
   localparam int LEN_W   = 6;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 cmd_valid = 1'b0;
   logic                 cmd_ready;
   logic [15:0]          cmd_addr = '0;
   logic [3:0]           cmd_req = '0;
   logic [LEN_W-1:0]     cmd_len = '0;
   logic [LEN_W-1:0]     cmd_rbuf = '0;
   logic [MAX_PAY*8-1:0] cmd_wdata = '0;
   logic                 tx_valid;
   logic                 tx_ready = 1'b0;
   logic [7:0]           tx_data;
   logic                 tx_last;
   logic                 rsp_valid = 1'b0;
   logic [7:0]           rsp_status = '0;
   logic [LEN_W-1:0]     rsp_len = '0;
   logic [MAX_PAY*8-1:0] rsp_data = '0;
   logic                 done_valid;
   logic [2:0]           done_result;
   logic [3:0]           done_reply;
   logic [LEN_W-1:0]     done_count;
   logic [MAX_PAY*8-1:0] done_data;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   aux_req_codec #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_req(cmd_req), .cmd_len(cmd_len), .cmd_rbuf(cmd_rbuf),
      .cmd_wdata(cmd_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_last(tx_last), .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_len(rsp_len),
      .rsp_data(rsp_data), .done_valid(done_valid), .done_result(done_result),
      .done_reply(done_reply), .done_count(done_count), .done_data(done_data)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_cmd(input logic [15:0] a, input logic [3:0] rq, input int len, input int rbuf,
                         input logic [127:0] wd, input int stall, input logic [7:0] st,
                         input int rlen, input logic [127:0] rd);
      int q[$];
      int kind, hi, lo, exp_res, exp_cnt, exp_rep, lim, pos, guard;
      bit wr, rdk;
      logic [127:0] exp_dat;
      kind = int'(rq) & 11;
      wr  = (kind == 0) || (kind == 8);
      rdk = (kind == 1) || (kind == 9);
      if (len > MAX_PAY)       exp_res = 4;
      else if (!(wr || rdk))   exp_res = 5;
      else if (st == 8'd1)     exp_res = 1;
      else if (st == 8'd2)     exp_res = 2;
      else if (st == 8'd3)     exp_res = 3;
      else                     exp_res = 0;

      chk(cmd_ready == 1'b1, "R9 ready before command", 128'(cmd_ready), 128'd1);
      cmd_addr = a; cmd_req = rq; cmd_len = LEN_W'(len); cmd_rbuf = LEN_W'(rbuf);
      cmd_wdata = wd; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;

      if (exp_res >= 4) begin
         chk(done_valid == 1'b1, exp_res == 4 ? "R4 done pulse" : "R6 done pulse", 128'(done_valid), 128'd1);
         chk(int'(done_result) == exp_res, exp_res == 4 ? "R4 result" : "R6 result", 128'(done_result), 128'(exp_res));
         chk(tx_valid == 1'b0, exp_res == 4 ? "R4 nothing sent" : "R6 nothing sent", 128'(tx_valid), 128'd0);
         @(negedge clk);
         chk(done_valid == 1'b0 && tx_valid == 1'b0, "R9 single pulse, R4/R6 silent", 128'({done_valid, tx_valid}), 128'd0);
         return;
      end

      lo = (len == 0) ? 0 : len - 1;
      hi = (len == 0) ? 3 : (wr ? ((4 + len) % 16) : 4);
      q.push_back(int'(a[7:0]));
      q.push_back(int'(a[15:8]));
      q.push_back(int'(rq) * 16);
      q.push_back(hi * 16 + lo);
      if (wr) for (int i = 0; i < len; i++) q.push_back(int'(wd[8*i +: 8]));

      pos = 0; guard = 0;
      while (q.size() > 0 && guard < 2000) begin
         bit rdy;
         guard++;
         chk(cmd_ready == 1'b0 && done_valid == 1'b0, "R9 busy while sending", 128'({cmd_ready, done_valid}), 128'd0);
         chk(tx_valid == 1'b1, "R5 byte valid", 128'(tx_valid), 128'd1);
         chk(int'(tx_data) == q[0],
             pos < 3 ? "R1 header byte" : (pos == 3 ? "R2/R3 length byte" : "R5 payload byte"),
             128'(tx_data), 128'(q[0]));
         chk(tx_last == (q.size() == 1), "R5 last marker", 128'(tx_last), 128'(q.size() == 1));
         rdy = ($urandom % 100) >= stall;
         tx_ready = rdy;
         @(negedge clk);
         if (rdy) begin
            void'(q.pop_front());
            pos++;
         end
      end
      tx_ready = 1'b0;
      if (guard >= 2000) chk(1'b0, "R5 stream stuck", 128'(q.size()), 128'd0);

      for (int i = 0; i < 2; i++) begin
         chk(tx_valid == 1'b0 && cmd_ready == 1'b0 && done_valid == 1'b0,
             "R5/R9 quiet while waiting", 128'({tx_valid, cmd_ready, done_valid}), 128'd0);
         @(negedge clk);
      end

      rsp_status = st; rsp_len = LEN_W'(rlen); rsp_data = rd; rsp_valid = 1'b1;
      @(negedge clk);
      rsp_valid = 1'b0;

      exp_dat = '0;
      if (exp_res != 0) begin
         exp_cnt = 0; exp_rep = 0;
      end else begin
         exp_rep = int'(st) / 16;
         if (wr) exp_cnt = len;
         else begin
            lim = (rlen < rbuf) ? rlen : rbuf;
            if (lim > MAX_PAY) lim = MAX_PAY;
            exp_cnt = lim;
            for (int i = 0; i < lim; i++) exp_dat[8*i +: 8] = rd[8*i +: 8];
         end
      end
      chk(done_valid == 1'b1 && cmd_ready == 1'b1, "R9 done with ready", 128'({done_valid, cmd_ready}), 128'd3);
      chk(int'(done_result) == exp_res, exp_res == 0 ? "R8 result ok" : "R7 result", 128'(done_result), 128'(exp_res));
      chk(int'(done_reply) == exp_rep, exp_res == 0 ? "R8 reply" : "R7 reply", 128'(done_reply), 128'(exp_rep));
      chk(int'(done_count) == exp_cnt, exp_res == 0 ? "R8 count" : "R7 count", 128'(done_count), 128'(exp_cnt));
      chk(done_data == exp_dat, exp_res == 0 ? "R8 data" : "R7 data", done_data, exp_dat);
      @(negedge clk);
      chk(done_valid == 1'b0, "R9 single pulse", 128'(done_valid), 128'd0);
   endtask

   initial begin
      logic [127:0] pat;
      pat = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
      repeat (3) @(negedge clk);
      chk(cmd_ready == 1'b0 || cmd_ready == 1'b1, "R9 reset known", 128'(cmd_ready), 128'd1);
      chk(tx_valid == 1'b0 && done_valid == 1'b0, "R5/R9 reset outputs low", 128'({tx_valid, done_valid}), 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R9 ready after reset", 128'(cmd_ready), 128'd1);

      do_cmd(16'h1234, 4'h8, 3, 0, pat, 0, 8'h00, 0, '0);          // R1 R2 R3 R5 write
      do_cmd(16'hbeef, 4'h9, 16, 16, '0, 30, 8'h00, 16, pat);       // R3 read, full 16
      do_cmd(16'h0050, 4'h4, 0, 0, '0, 0, 8'h00, 0, '0);            // R3 bare, R6 MOT ignored
      do_cmd(16'h0a0b, 4'h0, 16, 0, pat, 50, 8'h00, 0, '0);         // R3 wrap to 4
      do_cmd(16'h7fff, 4'hc, 12, 0, pat, 20, 8'h10, 0, '0);         // R3 wrap to 0, R8 write reply
      do_cmd(16'h00a0, 4'h5, 4, 4, '0, 40, 8'h20, 10, pat);         // R8 clamp to buffer
      do_cmd(16'h0100, 4'h1, 8, 30, '0, 0, 8'h00, 40, pat);         // R8 clamp to MAX_PAY
      do_cmd(16'h2222, 4'h9, 17, 16, pat, 0, 8'h00, 0, '0);         // R4 too big
      do_cmd(16'h3333, 4'h2, 2, 2, '0, 0, 8'h00, 0, '0);            // R6 invalid
      do_cmd(16'h3334, 4'ha, 1, 2, '0, 0, 8'h00, 0, '0);            // R6 invalid
      do_cmd(16'h3335, 4'h3, 40, 2, '0, 0, 8'h00, 0, '0);           // R4 priority over R6
      do_cmd(16'h4444, 4'h9, 2, 2, '0, 10, 8'h01, 2, pat);          // R7 timeout
      do_cmd(16'h4445, 4'h8, 2, 2, pat, 10, 8'h02, 0, '0);          // R7 flags
      do_cmd(16'h4446, 4'h1, 2, 2, '0, 10, 8'h03, 2, pat);          // R7 error
      do_cmd(16'h4447, 4'h9, 5, 8, '0, 60, 8'h13, 5, pat);          // R8 status 0x13 is ok
      for (int i = 0; i < 6; i++)
         do_cmd(16'(i * 997), 4'h8, i + 1, 0, pat ^ 128'(i), 70, 8'h00, 0, '0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule